// File: doc/BRIEF.md
# SMBus EEPROM Transaction Decoder

This block is the byte-level half of an SMBus slave. It sits behind a bit-level physical layer. That layer reports start and stop conditions, and it reports each byte clocked in from the master with a one-cycle strobe. For each byte, the decoder answers with an acknowledge decision. It keeps a 16-bit address pointer. It drives a simple memory port with one write strobe, one read strobe, one address and the data buses.

The command byte carries two meanings:

- A value from 80h to 9Fh is the high half of an EEPROM address.
  - The next byte is the low half, which sets the pointer.
  - An optional third byte is written at that address.
- A0h opens a fixed-length block write.
  - A count byte of 20h follows, then 32 data bytes, then a CRC-8 packet error check byte.
  - The data bytes are held inside the block. They are written to memory only after the check byte matches, so a corrupted block can be resent with no side effects.

A read transaction returns the byte at the pointer. A read transaction is an address byte with the read bit set.

Every memory access advances the pointer by one. Two permission inputs gate the memory side: one allows writes and one allows reads.

Top module: `smbe_xact_dec`

## Requirements
- R1: An address byte is acknowledged only when its upper seven bits equal the parameter SLV_ADDR. Bit 0 is the direction, with 1 meaning read. A mismatched address is refused, and every byte after it is refused until the next start.
- R2: The decision for a byte appears on `ack_vld`/`ack` in the cycle after its `ph_byte_vld` strobe. Any byte the decoder does not expect is answered with `ack` low.
- R3: A command from 80h to 9Fh is acknowledged, and the byte after it is acknowledged as the low address. The pointer becomes {command, low byte}. If the transaction stops there, no memory access happens.
- R4: A third byte after an address command is written at the pointer, and the pointer then advances by one. This happens only when `eep_ctl[1]` (write enable) is 1. When `eep_ctl[1]` is 0, the byte is refused and nothing is written.
- R5: Command A0h is acknowledged only when `eep_ctl[1]` is 1. The next byte must equal 20h. Any other count is refused, and the rest of the transaction is ignored.
- R6: The 32 data bytes of a block are acknowledged. The next byte is compared with a CRC-8 computed over the write address byte, A0h, the count and the data (polynomial x^8+x^2+x+1, initial value 0). On a match it is acknowledged, and the 32 bytes are written to consecutive addresses starting at the pointer. On a mismatch it is refused, and nothing is written.
- R7: A start or a stop before the check byte of a block discards the block, and no data is written.
- R8: A read address byte is acknowledged only when `eep_ctl[0]` (read enable) is 1. If it is acknowledged, the byte at the pointer appears on `tx_data` two cycles after the address strobe, and the pointer advances by one. If it is not acknowledged, no read is issued.
- R9: Any command outside 80h to 9Fh and other than A0h is refused.
- R10: After reset, `ack_vld`, `ack`, `mem_we` and `mem_re` are 0, and the pointer is 0.
- R11: While a block is still being written to memory, an address byte is refused, and reads and writes never overlap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ph_start | input | 1 | Start or repeated start seen (one-cycle pulse) |
| ph_stop | input | 1 | Stop seen (one-cycle pulse) |
| ph_byte_vld | input | 1 | A byte from the master is available (one-cycle pulse) |
| ph_byte | input | 8 | Byte from the master |
| eep_ctl | input | 2 | Bit 1 write enable, bit 0 read enable |
| ack_vld | output | 1 | Acknowledge decision valid |
| ack | output | 1 | 1 = acknowledge, 0 = refuse |
| tx_data | output | 8 | Byte to return on a read |
| mem_we | output | 1 | Memory write strobe |
| mem_re | output | 1 | Memory read strobe |
| mem_addr | output | AW | Memory address (the pointer) |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, valid in the same cycle as the address |

## Verification
The assertions assume the following about the physical layer:

- `ph_start`, `ph_stop` and `ph_byte_vld` are one-cycle pulses, and no two of them are high together.
- The master does not address the slave again until a block commit has had time to finish.
- `mem_rdata` depends only on `mem_addr` within a cycle.

The bench drives every event as a single-cycle pulse with an idle cycle between events. It waits well past the 32-cycle commit before reading memory back. Its memory model answers reads combinationally from the address.

// File: rtl/smbe_pkg.sv
// Package: shared state type and the packet-check CRC step for the
// transaction decoder. Assumes the CRC-8 polynomial 07h, MSB first.
package smbe_pkg;

    typedef enum logic [3:0] {
        ST_IDLE, ST_ADDR, ST_CMD, ST_LOW, ST_DATA,
        ST_CNT, ST_BLK, ST_PEC, ST_IGN
    } smbe_st_e;

    // Fold one byte into a CRC-8 remainder.
    function automatic logic [7:0] crc8_step(input logic [7:0] c, input logic [7:0] d);
        logic [7:0] r;
        r = c ^ d;
        for (int i = 0; i < 8; i++) begin
            r = r[7] ? ((r << 1) ^ 8'h07) : (r << 1);
        end
        return r;
    endfunction

endpackage

// File: rtl/smbe_crc8.sv
// CRC-8 accumulator for the packet check. It clears on clr, which has
// priority, and folds din in on en. Assumes clr and en come from the
// decoder's start and byte events.
module smbe_crc8 (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       en,
    input  logic [7:0] din,
    output logic [7:0] crc
);
    import smbe_pkg::*;

    // Hold the running remainder.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) crc <= 8'h00;
        else if (en)       crc <= crc8_step(crc, din);
    end
endmodule

// File: rtl/smbe_blkbuf.sv
// Block staging buffer and commit sequencer. Bytes are stored by index
// while a block arrives. On go, all BLK_LEN bytes are replayed, one per
// cycle, as write strobes. Assumes go is never raised while busy.
module smbe_blkbuf #(
    parameter int BLK_LEN = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr,
    input  logic [$clog2(BLK_LEN)-1:0] wr_idx,
    input  logic [7:0]                 wr_data,
    input  logic                       go,
    output logic                       busy,
    output logic                       c_we,
    output logic [7:0]                 c_data
);
    localparam int IW = $clog2(BLK_LEN);
    localparam logic [IW-1:0] LAST = IW'(BLK_LEN - 1);

    logic [7:0]    store_q [BLK_LEN];
    logic [IW-1:0] idx_q;

    // Capture incoming block bytes.
    always_ff @(posedge clk) begin
        if (wr) store_q[wr_idx] <= wr_data;
    end

    // Step the replay index while committing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            idx_q <= '0;
        end else if (go) begin
            busy  <= 1'b1;
            idx_q <= '0;
        end else if (busy) begin
            idx_q <= idx_q + IW'(1);
            if (idx_q == LAST) busy <= 1'b0;
        end
    end

    assign c_we   = busy;
    assign c_data = store_q[idx_q];

    AST_GO_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        go |-> !busy); // R11
    AST_COMMIT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (busy && idx_q == $past(idx_q) + IW'(1)) || (!busy && $past(idx_q) == LAST)); // R6
endmodule

// File: rtl/smbe_xact_dec.sv
// SMBus slave transaction decoder. It turns byte and start/stop events
// into acknowledge decisions and memory accesses. It handles
// set-address, single-byte write, block write with a packet check, and
// receive-byte read. Assumes the event pulses are one cycle long and
// mutually exclusive, and that mem_rdata is combinational from mem_addr.
module smbe_xact_dec #(
    parameter logic [6:0] SLV_ADDR = 7'h2C,
    parameter int         BLK_LEN  = 32,
    parameter int         AW       = 16,
    parameter logic [7:0] CMD_BLK  = 8'hA0,
    parameter logic [7:0] HI_MIN   = 8'h80,
    parameter logic [7:0] HI_MAX   = 8'h9F
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ph_start,
    input  logic          ph_stop,
    input  logic          ph_byte_vld,
    input  logic [7:0]    ph_byte,
    input  logic [1:0]    eep_ctl,
    output logic          ack_vld,
    output logic          ack,
    output logic [7:0]    tx_data,
    output logic          mem_we,
    output logic          mem_re,
    output logic [AW-1:0] mem_addr,
    output logic [7:0]    mem_wdata,
    input  logic [7:0]    mem_rdata
);
    import smbe_pkg::*;

    localparam int IW = $clog2(BLK_LEN);
    localparam logic [IW-1:0] LAST = IW'(BLK_LEN - 1);
    localparam logic [7:0] CNT_CODE = 8'(BLK_LEN);

    smbe_st_e      st;
    logic [AW-1:0] ptr;
    logic [7:0]    hi_q, wd_q, crc;
    logic [IW-1:0] blk_cnt;
    logic          swe_q, re_q, busy, c_we;
    logic [7:0]    c_data;
    logic          byte_ev, crc_en, buf_wr, pec_ok;

    assign byte_ev = ph_byte_vld && !ph_start && !ph_stop;
    assign crc_en  = byte_ev && (st == ST_ADDR || st == ST_CMD || st == ST_CNT || st == ST_BLK);
    assign buf_wr  = byte_ev && st == ST_BLK;
    assign pec_ok  = byte_ev && st == ST_PEC && ph_byte == crc;

    smbe_crc8 u_crc (
        .clk(clk), .rst_n(rst_n), .clr(ph_start), .en(crc_en), .din(ph_byte), .crc(crc)
    );

    smbe_blkbuf #(.BLK_LEN(BLK_LEN)) u_buf (
        .clk(clk), .rst_n(rst_n), .wr(buf_wr), .wr_idx(blk_cnt), .wr_data(ph_byte),
        .go(pec_ok), .busy(busy), .c_we(c_we), .c_data(c_data)
    );

    // Transaction state, acknowledge decision, pointer and read capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= ST_IDLE;
            ptr     <= '0;
            hi_q    <= '0;
            wd_q    <= '0;
            blk_cnt <= '0;
            swe_q   <= 1'b0;
            re_q    <= 1'b0;
            ack_vld <= 1'b0;
            ack     <= 1'b0;
            tx_data <= '0;
        end else begin
            ack_vld <= 1'b0;
            ack     <= 1'b0;
            swe_q   <= 1'b0;
            re_q    <= 1'b0;
            if (re_q) tx_data <= mem_rdata;
            if (mem_we || mem_re) ptr <= ptr + AW'(1);
            if (ph_start) begin
                st      <= ST_ADDR;
                blk_cnt <= '0;
            end else if (ph_stop) begin
                st <= ST_IDLE;
            end else if (ph_byte_vld) begin
                ack_vld <= 1'b1;
                st      <= ST_IGN;
                case (st)
                    ST_ADDR: if (ph_byte[7:1] == SLV_ADDR && !busy) begin
                        if (!ph_byte[0]) begin
                            ack <= 1'b1;
                            st  <= ST_CMD;
                        end else if (eep_ctl[0]) begin
                            ack  <= 1'b1;
                            re_q <= 1'b1;
                        end
                    end
                    ST_CMD: if (ph_byte >= HI_MIN && ph_byte <= HI_MAX) begin
                        ack  <= 1'b1;
                        hi_q <= ph_byte;
                        st   <= ST_LOW;
                    end else if (ph_byte == CMD_BLK && eep_ctl[1]) begin
                        ack <= 1'b1;
                        st  <= ST_CNT;
                    end
                    ST_LOW: begin
                        ack <= 1'b1;
                        ptr <= AW'({hi_q, ph_byte});
                        st  <= ST_DATA;
                    end
                    ST_DATA: if (eep_ctl[1]) begin
                        ack   <= 1'b1;
                        swe_q <= 1'b1;
                        wd_q  <= ph_byte;
                    end
                    ST_CNT: if (ph_byte == CNT_CODE) begin
                        ack     <= 1'b1;
                        blk_cnt <= '0;
                        st      <= ST_BLK;
                    end
                    ST_BLK: begin
                        ack     <= 1'b1;
                        blk_cnt <= blk_cnt + IW'(1);
                        st      <= (blk_cnt == LAST) ? ST_PEC : ST_BLK;
                    end
                    ST_PEC: ack <= pec_ok;
                    default: ack <= 1'b0;
                endcase
            end
        end
    end

    assign mem_we    = swe_q | c_we;
    assign mem_re    = re_q;
    assign mem_addr  = ptr;
    assign mem_wdata = c_we ? c_data : wd_q;

    AST_ACK_AFTER_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        ack_vld |-> $past(ph_byte_vld)); // R2
    AST_SINGLE_NEEDS_WEN: assert property (@(posedge clk) disable iff (!rst_n)
        swe_q |-> $past(eep_ctl[1])); // R4
    AST_READ_NEEDS_REN: assert property (@(posedge clk) disable iff (!rst_n)
        mem_re |-> $past(eep_ctl[0])); // R8
    AST_NO_RW_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we && mem_re)); // R11
    AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we || mem_re) |=> ptr == $past(ptr) + AW'(1)); // R4
endmodule

// File: tb/sim_smbe_xact_dec.sv
// Directed bench for the transaction decoder, one task per scenario.
module sim_smbe_xact_dec;
    localparam int CLK_PERIOD = 10;
    localparam logic [7:0] AW_BYTE = 8'h58;   // 2Ch, write
    localparam logic [7:0] AR_BYTE = 8'h59;   // 2Ch, read

    logic clk = 1'b0, rst_n = 1'b0;
    logic ph_start = 0, ph_stop = 0, ph_byte_vld = 0;
    logic [7:0] ph_byte = '0;
    logic [1:0] eep_ctl = 2'b11;
    logic ack_vld, ack, mem_we, mem_re;
    logic [7:0] tx_data, mem_wdata, mem_rdata;
    logic [15:0] mem_addr;

    logic [7:0] bmem [0:8191];
    int nwr = 0;
    int n_cmp = 0, n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    smbe_xact_dec u0 (
        .clk(clk), .rst_n(rst_n), .ph_start(ph_start), .ph_stop(ph_stop),
        .ph_byte_vld(ph_byte_vld), .ph_byte(ph_byte), .eep_ctl(eep_ctl),
        .ack_vld(ack_vld), .ack(ack), .tx_data(tx_data), .mem_we(mem_we),
        .mem_re(mem_re), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    assign mem_rdata = bmem[mem_addr[12:0]];
    always @(posedge clk) if (mem_we) begin
        bmem[mem_addr[12:0]] <= mem_wdata;
        nwr <= nwr + 1;
    end

    function automatic logic [7:0] crc_in(input logic [7:0] c, input logic [7:0] d);
        logic [7:0] r = c ^ d;
        for (int k = 0; k < 8; k++) r = r[7] ? ((r << 1) ^ 8'h07) : (r << 1);
        return r;
    endfunction

    task automatic check(input string rq, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    task automatic ev_start();
        @(negedge clk) ph_start = 1;
        @(negedge clk) ph_start = 0;
    endtask
    task automatic ev_stop();
        @(negedge clk) ph_stop = 1;
        @(negedge clk) ph_stop = 0;
    endtask
    task automatic send(input logic [7:0] b, output logic a);
        @(negedge clk) begin ph_byte_vld = 1; ph_byte = b; end
        @(negedge clk) begin
            ph_byte_vld = 0;
            a = ack_vld ? ack : 1'bx;
        end
    endtask

    task automatic set_ptr(input logic [7:0] hi, input logic [7:0] lo);
        logic a;
        ev_start(); send(AW_BYTE, a); send(hi, a); send(lo, a); ev_stop();
    endtask

    task automatic read_at_ptr(input string rq, input logic expect_ack, input logic [7:0] exp);
        logic a;
        ev_start(); send(AR_BYTE, a);
        check(rq, a, expect_ack);
        @(negedge clk);
        if (expect_ack) check(rq, tx_data, exp);
        ev_stop();
    endtask

    task automatic t_reset();
        check("R10 ack_vld", ack_vld, 0);
        check("R10 mem_we", mem_we, 0);
        check("R10 mem_re", mem_re, 0);
        check("R10 ptr", mem_addr, 0);
    endtask

    task automatic t_addr_mismatch();
        logic a;
        ev_start(); send(8'h40, a); check("R1 wrong addr", a, 0);
        send(8'h81, a); check("R1 ignored after mismatch", a, 0);
        ev_stop();
    endtask

    task automatic t_bad_cmd();
        logic a;
        ev_start(); send(AW_BYTE, a); check("R1 addr ack", a, 1);
        send(8'h7F, a); check("R9 cmd 7F", a, 0);
        ev_stop();
        ev_start(); send(AW_BYTE, a); send(8'hA1, a); check("R9 cmd A1", a, 0);
        ev_stop();
    endtask

    task automatic t_set_addr_read();
        logic a; int w0 = nwr;
        bmem[13'h0123] = 8'hC4; bmem[13'h0124] = 8'h3B;
        ev_start(); send(AW_BYTE, a); send(8'h81, a); check("R3 hi ack", a, 1);
        send(8'h23, a); check("R3 lo ack", a, 1); ev_stop();
        check("R3 no write", nwr, w0);
        read_at_ptr("R8 read", 1, 8'hC4);
        read_at_ptr("R8 ptr advanced", 1, 8'h3B);
    endtask

    task automatic t_single_write();
        logic a; int w0;
        eep_ctl = 2'b01; w0 = nwr;
        ev_start(); send(AW_BYTE, a); send(8'h90, a); send(8'h10, a);
        send(8'hA7, a); check("R4 write refused", a, 0); ev_stop();
        check("R4 no write when disabled", nwr, w0);
        eep_ctl = 2'b11;
        ev_start(); send(AW_BYTE, a); send(8'h90, a); send(8'h10, a);
        send(8'h6D, a); check("R4 write ack", a, 1); ev_stop();
        check("R4 one write", nwr, w0 + 1);
        check("R4 data", bmem[13'h1010], 8'h6D);
        bmem[13'h1011] = 8'h91;
        read_at_ptr("R4 ptr +1", 1, 8'h91);
    endtask

    task automatic t_read_disabled();
        eep_ctl = 2'b10;
        read_at_ptr("R8 read refused", 0, 8'h00);
        eep_ctl = 2'b11;
    endtask

    task automatic send_block(input logic [7:0] seed, input logic corrupt,
                              input int stop_after, output logic pa);
        logic a; logic [7:0] c = 8'h00; int nok = 0;
        ev_start();
        send(AW_BYTE, a); c = crc_in(c, AW_BYTE);
        send(8'hA0, a);   c = crc_in(c, 8'hA0); check("R5 A0 ack", a, 1);
        send(8'h20, a);   c = crc_in(c, 8'h20); check("R5 count ack", a, 1);
        for (int i = 0; i < 32; i++) begin
            if (i == stop_after) begin ev_stop(); pa = 0; return; end
            send(seed + 8'(i), a); c = crc_in(c, seed + 8'(i));
            if (a) nok++;
        end
        check("R6 data acks", nok, 32);
        send(corrupt ? ~c : c, pa);
    endtask

    task automatic t_block_ok();
        logic pa; int w0;
        set_ptr(8'h85, 8'hF0); w0 = nwr;
        send_block(8'h40, 0, 99, pa);
        check("R6 pec ack", pa, 1);
        ev_stop();
        repeat (40) @(negedge clk);
        check("R6 32 writes", nwr, w0 + 32);
        check("R6 first byte", bmem[13'h05F0], 8'h40);
        check("R6 last byte", bmem[13'h060F], 8'h5F);
        bmem[13'h0610] = 8'hE2;
        read_at_ptr("R6 ptr after block", 1, 8'hE2);
    endtask

    task automatic t_block_bad_pec();
        logic pa; int w0;
        set_ptr(8'h86, 8'h40); w0 = nwr;
        send_block(8'h11, 1, 99, pa);
        check("R6 bad pec nack", pa, 0);
        ev_stop(); repeat (40) @(negedge clk);
        check("R6 no writes on bad pec", nwr, w0);
    endtask

    task automatic t_block_abort();
        logic pa; int w0;
        set_ptr(8'h87, 8'h00); w0 = nwr;
        send_block(8'h22, 0, 10, pa);
        repeat (40) @(negedge clk);
        check("R7 stop aborts", nwr, w0);
        bmem[13'h0700] = 8'h5C;
        read_at_ptr("R7 ptr kept", 1, 8'h5C);
    endtask

    task automatic t_bad_count();
        logic a;
        ev_start(); send(AW_BYTE, a); send(8'hA0, a);
        send(8'h10, a); check("R5 bad count", a, 0);
        send(8'h00, a); check("R5 ignored after bad count", a, 0);
        ev_stop();
        eep_ctl = 2'b01;
        ev_start(); send(AW_BYTE, a); send(8'hA0, a); check("R5 A0 without enable", a, 0);
        ev_stop();
        eep_ctl = 2'b11;
    endtask

    task automatic t_busy_nack();
        logic pa, a;
        set_ptr(8'h88, 8'h00);
        send_block(8'h70, 0, 99, pa);
        ev_start(); send(AR_BYTE, a);
        check("R11 addr refused while committing", a, 0);
        ev_stop(); repeat (40) @(negedge clk);
        check("R11 commit completed", bmem[13'h081F], 8'h8F);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 8192; i++) bmem[i] = 8'h00;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1;
        @(negedge clk);
        t_addr_mismatch();
        t_bad_cmd();
        t_set_addr_read();
        t_single_write();
        t_read_disabled();
        t_block_ok();
        t_block_bad_pec();
        t_block_abort();
        t_bad_count();
        t_busy_nack();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule